// File: doc/BRIEF.md
# MESI Write-Policy Controller

This block sits between a processor's store path and a data cache whose lines carry MESI states. It accepts one write request at a time: an address, up to eight bytes of data with a byte mask, and the page-level write-through attribute. It asks the tag array for the line's current state. From that state it decides whether the data array is written and whether a write-through bus cycle goes out to memory.

A write that misses is sent to memory only. No line is allocated. A write that hits an exclusive or modified line stays inside the cache, and the line becomes modified. A write that hits a shared line updates the cache and also goes to memory. While that memory write is in flight, a system writeback/writethrough input is sampled. It decides whether the shared line is promoted to exclusive. The new state is written to the tag array only after the bus acknowledges the memory write.

The tag and data arrays, bus arbitration and snooping live outside this block.

Top module: `mesi_wr_ctrl`

## Requirements
- R1: Line states use a 2-bit code on `lkp_state` and `st_new`: invalid 00, shared 01, exclusive 10, modified 11.
- R2: When the looked-up state is invalid (a miss), the block writes neither the data array nor the state. It issues exactly one write-through bus cycle carrying the request's address, data and byte mask, and that cycle is held until `bus_ack`.
- R3: On any hit, `arr_we` equals the request's byte mask for exactly one cycle. That cycle is the first cycle after acceptance, in which `lkp_en` is high. `arr_data` and `cur_addr` carry the request. In every other cycle `arr_we` is zero.
- R4: On a hit to an exclusive or modified line, no bus cycle is issued. `st_we` pulses in the second cycle after acceptance with `st_new` = modified.
- R5: On a hit to a shared line with `req_pwt` high, a write-through bus cycle is issued and the line is rewritten as shared, whatever `bus_wbwt` is.
- R6: On a hit to a shared line with `req_pwt` low, a write-through bus cycle is issued. The line is rewritten as exclusive if `bus_wbwt` is high in the cycle where `bus_ack` is high, and as shared if it is low. `bus_wbwt` in any other cycle has no effect.
- R7: After a write-through cycle, `st_we` pulses for one cycle. It comes in the cycle right after the `bus_ack` cycle, never earlier.
- R8: `req_pcd`, `req_cacheable` and `dbg_mode` change neither the array write, the bus traffic nor the resulting line state.
- R9: While `rst_n` is low at a clock edge, the block returns to idle: `busy`, `bus_req`, `st_we` and `arr_we` are all low.
- R10: A request is taken only while `busy` is low. `busy` stays high from acceptance until the transaction ends: 2 cycles for an exclusive/modified hit, wait+2 for a miss, and wait+3 for a shared hit, where wait is the number of cycles `bus_req` is high before `bus_ack`. A `req_valid` seen while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 8*DATA_BYTES | Write data |
| req_be | input | DATA_BYTES | Byte mask |
| req_pwt | input | 1 | Page write-through attribute |
| req_pcd | input | 1 | Page cache-disable attribute (no effect on writes) |
| req_cacheable | input | 1 | Cacheable-cycle indication (no effect on writes) |
| dbg_mode | input | 1 | Debug mode, caches never filled (no effect on writes) |
| busy | output | 1 | Transaction in progress, new requests dropped |
| lkp_en | output | 1 | Tag lookup strobe |
| cur_addr | output | ADDR_W | Address of the current request for tag/data arrays |
| lkp_state | input | 2 | Line state returned by the tag lookup |
| arr_we | output | DATA_BYTES | Data-array byte write enables |
| arr_data | output | 8*DATA_BYTES | Data-array write data |
| bus_req | output | 1 | Write-through bus cycle request |
| bus_addr | output | ADDR_W | Bus write address |
| bus_data | output | 8*DATA_BYTES | Bus write data |
| bus_be | output | DATA_BYTES | Bus byte enables |
| bus_ack | input | 1 | Bus write complete |
| bus_wbwt | input | 1 | System writeback/writethrough indication |
| st_we | output | 1 | Line-state write strobe |
| st_new | output | 2 | New line state |

## Verification
The array write is due in the first cycle after the accepting edge. The state write is due two cycles after acceptance for an exclusive or modified hit, and one cycle after the acknowledge for a shared hit. The bus request holds from the second cycle until the acknowledge cycle. The bench samples every output at the falling edge of each cycle of a transaction and records the cycle index of each event. It compares those indices against the expected ones and so does not simply wait for a strobe. The bus responder drives the complement of the wanted writeback/writethrough value in every non-acknowledge cycle. A capture in the wrong cycle therefore shows up as a wrong state.

// File: rtl/mesi_wr_pkg.sv
// Shared encodings for the MESI write-policy controller.
// Assumes: line states are a 2-bit code fixed by the tag array.
package mesi_wr_pkg;

    // Line state code as stored in the tag array
    localparam logic [1:0] LS_I = 2'b00;
    localparam logic [1:0] LS_S = 2'b01;
    localparam logic [1:0] LS_E = 2'b10;
    localparam logic [1:0] LS_M = 2'b11;

    // Controller sequencing states
    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_LOOKUP = 2'd1,
        C_BUSWR  = 2'd2,
        C_COMMIT = 2'd3
    } ctl_st_t;

endpackage

// File: rtl/mesi_wr_policy.sv
// Write-policy decision for one line state.
// Does: classifies hit/miss, says whether a write-through cycle is needed,
//       and gives the line state to store after the write.
// Assumes: wbwt is only meaningful for a shared line with pwt clear.
module mesi_wr_policy
    import mesi_wr_pkg::*;
(
    input  logic [1:0] line_st,
    input  logic       pwt,
    input  logic       wbwt,
    output logic       hit,
    output logic       need_wt,
    output logic [1:0] next_st
);

    // Purpose: pure combinational classification of the write
    always_comb begin
        hit     = (line_st != LS_I);
        need_wt = (line_st == LS_I) || (line_st == LS_S);
        case (line_st)
            LS_I:    next_st = LS_I;
            LS_S:    next_st = (!pwt && wbwt) ? LS_E : LS_S;
            default: next_st = LS_M;
        endcase
    end

endmodule

// File: rtl/mesi_wr_seq.sv
// Sequencer and request holding registers for the write-policy controller.
// Does: accepts a request in idle, strobes the lookup, writes the array on a
//       hit, runs the write-through bus cycle, then commits the line state.
// Assumes: lkp_state is valid in the lookup cycle; bus_wbwt is valid with
//          bus_ack; the decision inputs come from mesi_wr_policy instances.
module mesi_wr_seq
    import mesi_wr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8,
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [DATA_BYTES-1:0] req_be,
    input  logic                  req_pwt,
    input  logic [1:0]            lkp_state,
    input  logic                  lk_hit,
    input  logic                  lk_need_wt,
    input  logic [1:0]            cm_next,
    input  logic                  bus_ack,
    input  logic                  bus_wbwt,
    output logic                  busy,
    output logic                  lkp_en,
    output logic [ADDR_W-1:0]     cur_addr,
    output logic [DATA_BYTES-1:0] arr_we,
    output logic [DATA_W-1:0]     arr_data,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_data,
    output logic [DATA_BYTES-1:0] bus_be,
    output logic                  st_we,
    output logic [1:0]            st_new,
    output logic [1:0]            line_q,
    output logic                  pwt_q,
    output logic                  wbwt_q
);

    ctl_st_t               fsm;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     data_q;
    logic [DATA_BYTES-1:0] be_q;

    // Purpose: advance the transaction state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm <= C_IDLE;
        end else begin
            case (fsm)
                C_IDLE:   if (req_valid) fsm <= C_LOOKUP;
                C_LOOKUP: fsm <= lk_need_wt ? C_BUSWR : C_COMMIT;
                C_BUSWR:  if (bus_ack) fsm <= (line_q == LS_S) ? C_COMMIT : C_IDLE;
                default:  fsm <= C_IDLE;
            endcase
        end
    end

    // Purpose: hold the request, lookup result and sampled wb/wt for the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
            pwt_q  <= 1'b0;
            line_q <= LS_I;
            wbwt_q <= 1'b0;
        end else begin
            if (fsm == C_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_data;
                be_q   <= req_be;
                pwt_q  <= req_pwt;
            end
            if (fsm == C_LOOKUP) line_q <= lkp_state;
            if (fsm == C_BUSWR && bus_ack) wbwt_q <= bus_wbwt;
        end
    end

    // Purpose: decode outputs from the sequencing state and held request
    always_comb begin
        busy     = (fsm != C_IDLE);
        lkp_en   = (fsm == C_LOOKUP);
        cur_addr = addr_q;
        arr_we   = (fsm == C_LOOKUP && lk_hit) ? be_q : '0;
        arr_data = data_q;
        bus_req  = (fsm == C_BUSWR);
        bus_addr = addr_q;
        bus_data = data_q;
        bus_be   = be_q;
        st_we    = (fsm == C_COMMIT);
        st_new   = cm_next;
    end

    // ---- assertions guarding the sequencing ----
    p_miss_no_arr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_en && lkp_state == LS_I) |-> (arr_we == '0));

    p_em_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_en && lkp_state[1]) |=> (!bus_req && st_we && st_new == LS_M));

    p_pwt_keeps_s_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && line_q == LS_S && pwt_q) |-> (st_new == LS_S));

    p_s_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && line_q == LS_S) |=> st_we);

    p_st_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> !st_we);

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_be)));

    p_bus_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);

endmodule

// File: rtl/mesi_wr_ctrl.sv
// Top of the MESI write-policy controller.
// Does: wires the lookup-time and commit-time policy decisions to the
//       sequencer. Page cache-disable, cacheable indication and debug mode
//       are accepted but do not alter write handling.
// Assumes: one outstanding write; external tag array, data array and bus.
module mesi_wr_ctrl
    import mesi_wr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8,
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [DATA_BYTES-1:0] req_be,
    input  logic                  req_pwt,
    input  logic                  req_pcd,
    input  logic                  req_cacheable,
    input  logic                  dbg_mode,
    output logic                  busy,
    output logic                  lkp_en,
    output logic [ADDR_W-1:0]     cur_addr,
    input  logic [1:0]            lkp_state,
    output logic [DATA_BYTES-1:0] arr_we,
    output logic [DATA_W-1:0]     arr_data,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_data,
    output logic [DATA_BYTES-1:0] bus_be,
    input  logic                  bus_ack,
    input  logic                  bus_wbwt,
    output logic                  st_we,
    output logic [1:0]            st_new
);

    logic       lk_hit, lk_need_wt;
    logic [1:0] lk_next;
    logic       cm_hit, cm_need_wt;
    logic [1:0] cm_next;
    logic [1:0] line_q;
    logic       pwt_q, wbwt_q;
    logic       unused_attr;

    // Purpose: attributes with no bearing on writes, gathered so they stay visible
    assign unused_attr = ^{req_pcd, req_cacheable, dbg_mode, lk_next, cm_hit, cm_need_wt};

    // Lookup-time decision on the live tag result
    mesi_wr_policy u_lk_policy (
        .line_st (lkp_state),
        .pwt     (req_pwt),
        .wbwt    (1'b0),
        .hit     (lk_hit),
        .need_wt (lk_need_wt),
        .next_st (lk_next)
    );

    // Commit-time decision on held state, attribute and sampled wb/wt
    mesi_wr_policy u_cm_policy (
        .line_st (line_q),
        .pwt     (pwt_q),
        .wbwt    (wbwt_q),
        .hit     (cm_hit),
        .need_wt (cm_need_wt),
        .next_st (cm_next)
    );

    mesi_wr_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_BYTES (DATA_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_be     (req_be),
        .req_pwt    (req_pwt),
        .lkp_state  (lkp_state),
        .lk_hit     (lk_hit),
        .lk_need_wt (lk_need_wt),
        .cm_next    (cm_next),
        .bus_ack    (bus_ack),
        .bus_wbwt   (bus_wbwt),
        .busy       (busy),
        .lkp_en     (lkp_en),
        .cur_addr   (cur_addr),
        .arr_we     (arr_we),
        .arr_data   (arr_data),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_be     (bus_be),
        .st_we      (st_we),
        .st_new     (st_new),
        .line_q     (line_q),
        .pwt_q      (pwt_q),
        .wbwt_q     (wbwt_q)
    );

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !bus_req && !st_we && arr_we == '0));

endmodule

// File: tb/mesi_wr_ctrl_tb.sv
module mesi_wr_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NB = 8;
    localparam int DW = 8 * NB;
    localparam int NV = 12;

    // st, pwt, pcd, cacheable, dbg, wbwt-at-ack, wait cycles, expected new state
    typedef struct packed {
        logic [1:0] st;
        logic       pwt;
        logic       pcd;
        logic       cch;
        logic       dbg;
        logic       wbwt;
        logic [3:0] wt;
        logic [1:0] exp_new;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 2'b00},  // R2 miss
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 2'b00},  // R2/R8 miss
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 2'b01},  // R5
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 2'b10},  // R6 upgrade
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 2'b01},  // R6 stays shared
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2, 2'b10},  // R6/R8 debug
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 2'b11},  // R4
        '{2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 2'b11},  // R4/R8
        '{2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 2'b11},  // R4
        '{2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'b11},  // R4/R8
        '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 2'b01},  // R5/R8
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 2'b00}   // R2/R8
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [NB-1:0] req_be = '0;
    logic          req_pwt = 1'b0, req_pcd = 1'b0, req_cacheable = 1'b1, dbg_mode = 1'b0;
    logic [1:0]    lkp_state = 2'b00;
    logic          bus_ack = 1'b0, bus_wbwt = 1'b0;
    logic          busy, lkp_en, bus_req, st_we;
    logic [AW-1:0] cur_addr, bus_addr;
    logic [NB-1:0] arr_we, bus_be;
    logic [DW-1:0] arr_data, bus_data;
    logic [1:0]    st_new;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mesi_wr_ctrl #(.ADDR_W(AW), .DATA_BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .req_pwt(req_pwt), .req_pcd(req_pcd),
        .req_cacheable(req_cacheable), .dbg_mode(dbg_mode), .busy(busy),
        .lkp_en(lkp_en), .cur_addr(cur_addr), .lkp_state(lkp_state),
        .arr_we(arr_we), .arr_data(arr_data), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
        .bus_ack(bus_ack), .bus_wbwt(bus_wbwt), .st_we(st_we), .st_new(st_new)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One transaction with a bus responder; every output sampled at negedge
    task automatic run_txn(input vec_t v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [NB-1:0] be, input bit pulse_extra);
        int cyc = 0, nbus = 0, nst = 0, waited = 0, ack_cyc = -1, st_cyc = -1, exp_cyc;
        bit arr_ok = 1, pay_ok = 1;
        logic [1:0] stv = 2'bxx;
        bit hit = (v.st != 2'b00);
        bit wt  = (v.st == 2'b00) || (v.st == 2'b01);
        bit attr = v.pcd || !v.cch || v.dbg;
        string base = (v.st == 2'b00) ? "R2" : (v.st[1] ? "R4" : (v.pwt ? "R5" : "R6"));
        string tag = attr ? {base, "/R8"} : base;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
        req_pwt = v.pwt; req_pcd = v.pcd; req_cacheable = v.cch; dbg_mode = v.dbg;
        lkp_state = v.st; bus_ack = 1'b0; bus_wbwt = ~v.wbwt;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_data = ~d; req_be = ~be; req_pwt = ~v.pwt;
        while (busy && cyc < 60) begin
            cyc++;
            if (cyc == 1) begin
                if (arr_we !== (hit ? be : '0) || cur_addr !== a || !lkp_en) arr_ok = 0;
                if (hit && arr_data !== d) arr_ok = 0;
            end else if (arr_we !== '0) arr_ok = 0;
            if (bus_req) begin
                nbus++;
                if (bus_addr !== a || bus_data !== d || bus_be !== be) pay_ok = 0;
            end
            if (st_we) begin
                nst++; stv = st_new; st_cyc = cyc;
                if (cur_addr !== a) pay_ok = 0;
            end
            if (pulse_extra && cyc == 2) begin
                req_valid = 1'b1; req_addr = a ^ 32'h40;
            end else req_valid = 1'b0;
            bus_ack = 1'b0; bus_wbwt = ~v.wbwt;
            if (bus_req) begin
                if (waited == int'(v.wt)) begin
                    bus_ack = 1'b1; bus_wbwt = v.wbwt; ack_cyc = cyc;
                end else waited++;
            end
            @(negedge clk);
        end
        bus_ack = 1'b0; req_valid = 1'b0;
        exp_cyc = !wt ? 2 : (v.st == 2'b01 ? int'(v.wt) + 3 : int'(v.wt) + 2);
        check(arr_ok, hit ? "R3" : "R2", "array write enable/data", arr_we, hit ? be : 0);
        check(nbus == (wt ? int'(v.wt) + 1 : 0), tag, "bus cycles", nbus, wt ? v.wt + 1 : 0);
        check(pay_ok, tag, "bus/array address and payload", bus_addr, a);
        check(nst == (hit ? 1 : 0), tag, "state write count", nst, hit ? 1 : 0);
        if (hit) begin
            check(stv === v.exp_new, {tag, "/R1"}, "new line state", stv, v.exp_new);
            check(st_cyc == (wt ? ack_cyc + 1 : 2), "R7", "state write cycle",
                  st_cyc, wt ? ack_cyc + 1 : 2);
        end
        check(cyc == exp_cyc, "R10", "busy length", cyc, exp_cyc);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !bus_req && !st_we && arr_we == '0, "R9", "idle after reset",
              {busy, bus_req, st_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_txn(VECS[i], 32'h1000 + 32'(i) * 32'h40,
                    {8{8'(i * 17 + 3)}} ^ 64'h0123_4567_89ab_cdef,
                    (i == 0) ? 8'hFF : (8'hA5 ^ 8'(i)), 1'b0);
        end

        // R10: request pulsed during a bus wait is dropped
        run_txn('{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 2'b00}, 32'h2000,
                64'hdead_beef_0bad_f00d, 8'h3C, 1'b1);
        repeat (3) @(negedge clk);
        check(!busy && !bus_req, "R10", "no second transaction after dropped request",
              busy, 0);

        // R9: reset in the middle of a bus cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3000; lkp_state = 2'b01; req_pwt = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(bus_req, "R9", "bus cycle open before reset", bus_req, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !bus_req && !st_we && arr_we == '0, "R9", "idle after mid-cycle reset",
              {busy, bus_req, st_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!st_we && !busy, "R9", "no late state write after reset", st_we, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule